// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block raises a sticky flag at a fixed, programmable rate and turns that flag into an interrupt request when the local enable is set. The time base comes from one of two single-cycle count enables, an internal reference tick or an oscillator tick, picked by a source-select input. Every cycle in which the selected tick is high and counting is allowed advances the timer by one. When a full period of ticks has gone by, the flag is set and the next period begins on the very next tick.

The period is held in an 8-bit register loaded by a write strobe. Its upper nibble is a power-of-two exponent and its lower nibble a modulus. The period is (modulus+1) × 2^(exponent+BASE_SHIFT) ticks, where BASE_SHIFT defaults to 10. A register value of zero parks the timer. Each write, whatever its value, starts the period over. Software clears the flag by pulsing a clear strobe.

While the chip is in stop mode the timer is frozen. It keeps counting only when three conditions hold together: pseudo-stop is active, the oscillator is the selected source, and the oscillator has been told to keep running in stop.

Top module: `rti_timer`

## Requirements
- R1: The source-select input chooses the count source: 0 counts cycles with `ref_tick` high, and 1 counts cycles with `osc_tick` high. The unselected tick has no effect on the count.
- R2: While `stop_act` is 1, the tick count is frozen and kept, unless the R3 condition holds. Counting resumes from the kept value when stop ends.
- R3: In stop mode, counting continues only when `pseudo_stop` is 1, `osc_in_stop` is 1 and `src_osc` is 1, all at the same time.
- R4: On the clock edge that samples the last tick of a period, `flag` becomes 1. The next period starts with the following tick, so under continuous ticks the timeouts are exactly one period apart.
- R5: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1.
- R6: A cycle with `period_wr` high loads `period_din` and restarts the period from zero ticks. A tick sampled in that same cycle is not counted.
- R7: A cycle with `flag_clr` high clears `flag` on the next edge. If a timeout occurs in the same cycle, the flag is set instead.
- R8: When the period register holds 0, no ticks are counted and `flag` is never set.
- R9: With `period_din[7:4]` = E and `period_din[3:0]` = M, the period is (M+1) × 2^(E+BASE_SHIFT) counted ticks.
- R10: Cycles in which the selected tick is low do not advance the count. A gapped tick stream therefore stretches the period in cycles but not in ticks.
- R11: After reset, `flag` and `irq` are 0 and the period register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_tick | input | 1 | Internal reference count enable |
| osc_tick | input | 1 | Oscillator count enable |
| src_osc | input | 1 | Source select: 0 reference, 1 oscillator |
| period_wr | input | 1 | Period register write strobe |
| period_din | input | 8 | Period value: [7:4] exponent, [3:0] modulus |
| irq_en | input | 1 | Local interrupt enable |
| flag_clr | input | 1 | Write-one clear of the flag |
| stop_act | input | 1 | Stop mode active |
| pseudo_stop | input | 1 | Stop mode is pseudo-stop |
| osc_in_stop | input | 1 | Oscillator kept running in stop |
| flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a timeout that lands in the same cycle as a clear. The stimulus reaches it by holding `flag_clr` high without a break. Every timeout then collides with a clear, which must leave the flag high for exactly one cycle. The gap between two such pulses also measures the back-to-back period.

A second hard case is a partly counted period frozen by stop mode. To reach it, the bench counts a known number of ticks, then walks through every stop combination that must halt the timer with both ticks running, and finally checks that only the remaining ticks are needed after stop ends.

A behavioural tick-count model runs through all directed and random phases and is compared with `flag` and `irq` on every clock.

// File: rtl/rti_pkg.sv
`timescale 1ns/1ps
package rti_pkg;

  // Count source encoding, matches the src_osc port
  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_OSC = 1'b1
  } rti_src_e;

  // Counting is allowed outside stop, or in pseudo-stop with the
  // oscillator selected and kept running (R2, R3)
  function automatic logic may_count(
    input logic     stop_act,
    input logic     pseudo_stop,
    input logic     osc_in_stop,
    input rti_src_e src
  );
    return !stop_act || (pseudo_stop && osc_in_stop && (src == SRC_OSC));
  endfunction

endpackage

// File: rtl/rti_rst_sync.sv
`timescale 1ns/1ps
module rti_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/rti_gate.sv
`timescale 1ns/1ps
module rti_gate
  import rti_pkg::*;
(
  input  rti_src_e src,
  input  logic     ref_tick,
  input  logic     osc_tick,
  input  logic     stop_act,
  input  logic     pseudo_stop,
  input  logic     osc_in_stop,
  input  logic     period_nz,
  output logic     cnt_en
);

  logic tick_sel;
  logic run_ok;

  always_comb begin
    // R1: source multiplexer
    unique case (src)
      SRC_OSC: tick_sel = osc_tick;
      default: tick_sel = ref_tick;
    endcase
    run_ok = may_count(stop_act, pseudo_stop, osc_in_stop, src);
    // R8: a zero period parks the timer
    cnt_en = tick_sel && run_ok && period_nz;
  end

endmodule

// File: rtl/rti_prescaler.sv
`timescale 1ns/1ps
module rti_prescaler #(
  parameter int EXP_W      = 4,
  parameter int BASE_SHIFT = 10,
  localparam int PRE_W     = BASE_SHIFT + (1 << EXP_W) - 1,
  localparam int SH_W      = $clog2(PRE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cnt_en,
  input  logic [EXP_W-1:0] expo,
  output logic [PRE_W-1:0] cnt,
  output logic             carry
);

  logic [SH_W-1:0]  shamt;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] last_val;
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;

  always_comb begin
    shamt    = SH_W'(expo) + SH_W'(BASE_SHIFT);
    span     = {{PRE_W{1'b0}}, 1'b1} << shamt;
    last_val = span[PRE_W-1:0] - PRE_W'(1);
    carry    = cnt_en && !restart && (cnt_q == last_val);
    cnt_d    = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = carry ? '0 : cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/rti_modulus.sv
`timescale 1ns/1ps
module rti_modulus #(
  parameter int MOD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             carry,
  input  logic [MOD_W-1:0] modv,
  output logic [MOD_W-1:0] cnt,
  output logic             timeout
);

  logic [MOD_W-1:0] cnt_q;
  logic [MOD_W-1:0] cnt_d;

  always_comb begin
    timeout = carry && (cnt_q == modv);
    cnt_d   = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (carry) begin
      cnt_d = timeout ? '0 : cnt_q + MOD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/rti_flag.sv
`timescale 1ns/1ps
module rti_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    // R7: a set event beats a clear in the same cycle
    if (timeout) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;

endmodule

// File: rtl/rti_timer.sv
`timescale 1ns/1ps
module rti_timer
  import rti_pkg::*;
#(
  parameter int EXP_W      = 4,
  parameter int MOD_W      = 4,
  parameter int BASE_SHIFT = 10,
  localparam int PER_W     = EXP_W + MOD_W,
  localparam int PRE_W     = BASE_SHIFT + (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             osc_tick,
  input  logic             src_osc,
  input  logic             period_wr,
  input  logic [PER_W-1:0] period_din,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             stop_act,
  input  logic             pseudo_stop,
  input  logic             osc_in_stop,
  output logic             flag,
  output logic             irq
);

  logic             rst_q_n;
  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] period_d;
  logic             cnt_en;
  logic             carry;
  logic             timeout;
  logic [PRE_W-1:0] pre_cnt;
  logic [MOD_W-1:0] mod_cnt;

  rti_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // Period register, write strobe is its clock enable
  always_comb begin
    period_d = period_wr ? period_din : period_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      period_q <= '0;
    end else begin
      period_q <= period_d;
    end
  end

  rti_gate u_gate (
    .src         (rti_src_e'(src_osc)),
    .ref_tick    (ref_tick),
    .osc_tick    (osc_tick),
    .stop_act    (stop_act),
    .pseudo_stop (pseudo_stop),
    .osc_in_stop (osc_in_stop),
    .period_nz   (|period_q),
    .cnt_en      (cnt_en)
  );

  rti_prescaler #(.EXP_W(EXP_W), .BASE_SHIFT(BASE_SHIFT)) u_pre (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .restart (period_wr),
    .cnt_en  (cnt_en),
    .expo    (period_q[PER_W-1:MOD_W]),
    .cnt     (pre_cnt),
    .carry   (carry)
  );

  rti_modulus #(.MOD_W(MOD_W)) u_mod (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .restart (period_wr),
    .carry   (carry),
    .modv    (period_q[MOD_W-1:0]),
    .cnt     (mod_cnt),
    .timeout (timeout)
  );

  rti_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .timeout (timeout),
    .clr     (flag_clr),
    .irq_en  (irq_en),
    .flag    (flag),
    .irq     (irq)
  );

endmodule

// File: rtl/rti_timer_chk.sv
`timescale 1ns/1ps
module rti_timer_chk #(
  parameter int PER_W = 8,
  parameter int PRE_W = 25,
  parameter int MOD_W = 4
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             flag,
  input logic             irq,
  input logic             irq_en,
  input logic             flag_clr,
  input logic             period_wr,
  input logic             stop_act,
  input logic             pseudo_stop,
  input logic             osc_in_stop,
  input logic             src_osc,
  input logic [PER_W-1:0] period_q,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [MOD_W-1:0] mod_cnt,
  input logic             timeout
);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    timeout |=> flag);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag_clr && !timeout) |=> !flag);

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(flag) |-> $past(timeout));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq |-> (flag && irq_en));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    period_wr |=> ((pre_cnt == '0) && (mod_cnt == '0)));

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stop_act && !(pseudo_stop && osc_in_stop && src_osc) && !period_wr)
      |=> ($stable(pre_cnt) && $stable(mod_cnt)));

  // R8
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (period_q == '0) |-> !timeout);

  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((period_q == '0) && !period_wr) |=> $stable(pre_cnt));

endmodule

bind rti_timer rti_timer_chk #(
  .PER_W (PER_W),
  .PRE_W (PRE_W),
  .MOD_W (MOD_W)
) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .flag        (flag),
  .irq         (irq),
  .irq_en      (irq_en),
  .flag_clr    (flag_clr),
  .period_wr   (period_wr),
  .stop_act    (stop_act),
  .pseudo_stop (pseudo_stop),
  .osc_in_stop (osc_in_stop),
  .src_osc     (src_osc),
  .period_q    (period_q),
  .pre_cnt     (pre_cnt),
  .mod_cnt     (mod_cnt),
  .timeout     (timeout)
);

// File: tb/sim_rti_timer.sv
`timescale 1ns/1ps
module sim_rti_timer;

  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0, osc_tick = 1'b0, src_osc = 1'b0;
  logic       period_wr = 1'b0;
  logic [7:0] period_din = 8'h00;
  logic       irq_en = 1'b0, flag_clr = 1'b0;
  logic       stop_act = 1'b0, pseudo_stop = 1'b0, osc_in_stop = 1'b0;
  logic       flag, irq;

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R11";

  // reference model state
  bit   m_flag = 1'b0;
  int   m_cnt = 0;
  logic [7:0] m_per = 8'h00;

  rti_timer #(.BASE_SHIFT(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_tick(osc_tick),
    .src_osc(src_osc), .period_wr(period_wr), .period_din(period_din),
    .irq_en(irq_en), .flag_clr(flag_clr), .stop_act(stop_act),
    .pseudo_stop(pseudo_stop), .osc_in_stop(osc_in_stop),
    .flag(flag), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic int period_ticks(input logic [7:0] p);
    return (int'(p[3:0]) + 1) << (int'(p[7:4]) + BASE);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model: counts ticks against the programmed period
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= 1'b0;
      m_cnt  <= 0;
      m_per  <= 8'h00;
    end else begin
      bit tk, go, hit;
      tk  = src_osc ? osc_tick : ref_tick;
      go  = !stop_act || (pseudo_stop && src_osc && osc_in_stop);
      hit = 1'b0;
      if (period_wr) begin
        m_cnt <= 0;
        m_per <= period_din;
      end else if (m_per != 8'h00 && tk && go) begin
        if (m_cnt + 1 == period_ticks(m_per)) begin
          hit = 1'b1;
          m_cnt <= 0;
        end else begin
          m_cnt <= m_cnt + 1;
        end
      end
      if (hit) m_flag <= 1'b1;
      else if (flag_clr) m_flag <= 1'b0;
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      check(flag === m_flag, {cur_req, " flag vs model"}, int'(flag), int'(m_flag));
      check(irq === (m_flag && irq_en), "R5 irq vs model", int'(irq), int'(m_flag && irq_en));
    end
  end

  task automatic summary_and_end();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      check(1'b0, "R4 watchdog", wd, 150000);
      summary_and_end();
    end
  end

  task automatic wr_period(input logic [7:0] v);
    period_din = v;
    period_wr  = 1'b1;
    @(negedge clk);
    period_wr  = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic wait_flag(input int lim, output int n);
    n = 0;
    while (flag !== 1'b1 && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n, t1, t2, nt;
    repeat (5) @(negedge clk);
    // R11 reset state
    check(flag === 1'b0, "R11 flag in reset", int'(flag), 0);
    check(irq === 1'b0, "R11 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    check(flag === 1'b0 && irq === 1'b0, "R11 after release", int'(flag), 0);

    // R9 / R4: E=0 M=1 -> 8 ticks
    cur_req = "R9";
    ref_tick = 1'b1;
    wr_period(8'h01);
    wait_flag(100, n);
    check(n == 8, "R9 period E0 M1", n, 8);

    // R5 irq gating
    cur_req = "R5";
    check(irq === 1'b0, "R5 irq off with enable low", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq === 1'b1, "R5 irq with enable high", int'(irq), 1);

    // R7 set beats clear, R4 back-to-back periods
    cur_req = "R7";
    flag_clr = 1'b1;
    @(negedge clk);
    while (flag !== 1'b1) @(negedge clk);
    t1 = wd;
    @(negedge clk);
    check(flag === 1'b0, "R7 clear after collision pulse", int'(flag), 0);
    while (flag !== 1'b1) @(negedge clk);
    t2 = wd;
    check(t2 - t1 == 8, "R4 back-to-back interval", t2 - t1, 8);
    flag_clr = 1'b0;
    @(negedge clk);
    irq_en = 1'b0;
    clr_flag();
    check(flag === 1'b0, "R7 plain clear", int'(flag), 0);

    // R1 source select
    cur_req = "R1";
    src_osc = 1'b1; osc_tick = 1'b0; ref_tick = 1'b1;
    wr_period(8'h01);
    repeat (20) @(negedge clk);
    check(flag === 1'b0, "R1 reference ignored when osc selected", int'(flag), 0);
    osc_tick = 1'b1;
    wait_flag(100, n);
    check(n == 8, "R1 osc ticks counted", n, 8);
    clr_flag();

    // R2 / R3 stop mode
    cur_req = "R2";
    ref_tick = 1'b1; osc_tick = 1'b1; src_osc = 1'b1;
    wr_period(8'h01);
    repeat (3) @(negedge clk);
    stop_act = 1'b1; pseudo_stop = 1'b0; osc_in_stop = 1'b1;
    repeat (10) @(negedge clk);
    pseudo_stop = 1'b1; osc_in_stop = 1'b0;
    repeat (10) @(negedge clk);
    osc_in_stop = 1'b1; src_osc = 1'b0;
    repeat (10) @(negedge clk);
    check(flag === 1'b0, "R2 halted in stop", int'(flag), 0);
    stop_act = 1'b0; pseudo_stop = 1'b0; osc_in_stop = 1'b0;
    wait_flag(100, n);
    check(n == 5, "R2 count kept across stop", n, 5);
    clr_flag();
    cur_req = "R3";
    src_osc = 1'b1;
    wr_period(8'h01);
    stop_act = 1'b1; pseudo_stop = 1'b1; osc_in_stop = 1'b1;
    wait_flag(100, n);
    check(n == 8, "R3 runs in pseudo-stop", n, 8);
    stop_act = 1'b0; pseudo_stop = 1'b0; osc_in_stop = 1'b0;
    clr_flag();

    // R6 write restarts
    cur_req = "R6";
    src_osc = 1'b0;
    wr_period(8'h01);
    repeat (6) @(negedge clk);
    wr_period(8'h01);
    wait_flag(100, n);
    check(n == 8, "R6 restart on rewrite", n, 8);
    clr_flag();

    // R8 zero period
    cur_req = "R8";
    wr_period(8'h00);
    repeat (100) @(negedge clk);
    check(flag === 1'b0, "R8 zero period never sets", int'(flag), 0);

    // R9 exponent and modulus fields: E=2 M=2 -> 48 ticks
    cur_req = "R9";
    wr_period(8'h22);
    wait_flag(200, n);
    check(n == 48, "R9 period E2 M2", n, 48);
    clr_flag();

    // R10 gapped ticks: E=1 M=0 -> 8 ticks
    cur_req = "R10";
    ref_tick = 1'b0;
    wr_period(8'h10);
    nt = 0; n = 0;
    while (flag !== 1'b1 && n < 100) begin
      ref_tick = (n % 2 == 1);
      if (ref_tick) nt++;
      @(negedge clk);
      n++;
    end
    check(nt == 8, "R10 ticks needed with gaps", nt, 8);
    check(n >= 15, "R10 cycles stretched by gaps", n, 15);
    clr_flag();

    // random mix, checked against the model every clock
    cur_req = "R4";
    for (int i = 0; i < 4000; i++) begin
      ref_tick    = ($urandom % 3) != 0;
      osc_tick    = ($urandom % 2) == 1;
      if (($urandom % 50) == 0) src_osc = ~src_osc;
      stop_act    = ($urandom % 5) == 0;
      pseudo_stop = ($urandom % 2) == 1;
      osc_in_stop = ($urandom % 2) == 1;
      flag_clr    = ($urandom % 9) == 0;
      if (($urandom % 40) == 0) irq_en = ~irq_en;
      if (($urandom % 300) == 0) begin
        period_din = {4'($urandom % 3), 4'($urandom % 16)};
        period_wr  = 1'b1;
      end else begin
        period_wr  = 1'b0;
      end
      @(negedge clk);
    end
    period_wr = 1'b0;
    repeat (2) @(negedge clk);
    summary_and_end();
  end

endmodule